// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It runs a small integer subset: word load, word store, add, subtract, AND, OR, signed set-on-less-than, branch-if-equal and an absolute jump. Inside the core are the following parts:

- a program counter
- a 32-entry register file
- an opcode decoder
- a second decoder that turns the opcode class and the R-type function field into an ALU operation code
- an ALU
- immediate sign extension
- next-address selection

Instruction memory and data memory sit outside the core. Both read combinationally. The instruction port shows the current program counter as a byte address. The data port shows an address, write data and separate read and write strobes. Memory is word-organised, so address bits [1:0] are not used to select a word.

Instruction fields follow a fixed layout:

| Bits | Field |
|------|-------|
| [31:26] | opcode |
| [25:21] | first source register |
| [20:16] | second source register, or the destination for a load |
| [15:11] | R-type destination |
| [5:0] | R-type function code |
| [15:0] | 16-bit immediate |
| [25:0] | 26-bit jump index |

Top module: `msc_core`

## Requirements
- R1: While `rst_ni` is low, `imem_addr_o` is 0 and both `dmem_we_o` and `dmem_re_o` are low. The first instruction after release is fetched from address 0.
- R2: The opcode is decoded from bits [31:26]: 0 is R-type, 35 is load, 43 is store, 4 is branch-if-equal and 2 is jump.
- R3: An R-type instruction writes the ALU result to register [15:11]. The function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A set-on-less-than. Set-on-less-than compares as signed two's complement and yields 1 or 0.
- R4: Register 0 always reads as zero, and a write that targets it has no effect.
- R5: A load drives `dmem_addr_o` with register [25:21] plus the sign-extended immediate and raises `dmem_re_o`. It writes `dmem_rdata_i` into register [20:16].
- R6: A store drives the same kind of address and puts the value of register [20:16] on `dmem_wdata_o`. `dmem_we_o` is high in exactly the cycles that execute a store.
- R7: When its two source registers are equal, branch-if-equal moves the PC to PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the PC moves to PC+4.
- R8: A jump loads the PC with the old PC bits [31:28], then the 26-bit index, then two zero bits.
- R9: Every other instruction advances the PC by 4.
- R10: An opcode outside the five listed behaves as a no-op: no register write, no memory strobe, and the PC advances by 4.
- R11: A register written by one instruction holds the new value when the next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Byte address of the current instruction |
| imem_rdata_i | input | 32 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | 32 | Byte address of the data access |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_re_o | output | 1 | Data read strobe |
| dmem_rdata_i | input | 32 | Data word at `dmem_addr_o` |

## Verification
A directed program runs first. It loads one positive and one negative operand and passes them through all five ALU functions, which separates signed from unsigned set-on-less-than and subtraction from addition. It then tries a write to register 0, an undefined opcode placed so that a wrong decode would change memory, a branch that is not taken, a branch that is taken, a jump over two stores, a negative load offset and a backward self-branch. After that, several seeded random programs mix every instruction class with register indices drawn from a small pool, so dependencies are frequent. An instruction-level model in the bench predicts the PC and every data-port transaction in each cycle. This catches mistakes in operand selection, register write-back or next-PC choice that a single directed result could hide.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RAW    = $clog2(NREG);
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;

  typedef enum logic [5:0] {
    OPC_RTYPE = 6'd0,
    OPC_JUMP  = 6'd2,
    OPC_BEQ   = 6'd4,
    OPC_LOAD  = 6'd35,
    OPC_STORE = 6'd43
  } opcode_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_fn_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef struct packed {
    logic    dst_rd;   // write-back index from [15:11] instead of [20:16]
    logic    src_imm;  // ALU operand b is the extended immediate
    logic    wb_mem;   // write-back value comes from data memory
    logic    reg_we;
    logic    mem_re;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/msc_main_dec.sv
module msc_main_dec
  import msc_pkg::*;
(
  input  logic [5:0] opc_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = AOP_ADD;
    case (opc_i)
      OPC_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.alu_op = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_re  = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OPC_JUMP: ctrl_o.jump = 1'b1;
      default: ; // undefined opcode: all enables stay low
    endcase
  end
endmodule

// File: rtl/msc_alu_dec.sv
module msc_alu_dec
  import msc_pkg::*;
(
  input  alu_op_e    aop_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);
  always_comb begin
    fn_o = ALU_ADD;
    case (aop_i)
      AOP_ADD: fn_o = ALU_ADD;
      AOP_SUB: fn_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_ADD:  fn_o = ALU_ADD;
          FN_SUB:  fn_o = ALU_SUB;
          FN_AND:  fn_o = ALU_AND;
          FN_OR:   fn_o = ALU_OR;
          FN_SLT:  fn_o = ALU_SLT;
          default: fn_o = ALU_ADD;
        endcase
      end
      default: fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/msc_alu.sv
module msc_alu
  import msc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic [W-1:0] diff;
  logic         lt;

  assign diff = a_i - b_i;
  // signed less-than from operand signs and the difference
  assign lt   = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff[W-1];

  always_comb begin
    case (fn_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = diff;
      ALU_SLT: res_o = {{(W-1){1'b0}}, lt};
      ALU_NOR: res_o = ~(a_i | b_i);
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/msc_regfile.sv
module msc_regfile
  import msc_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned N  = NREG,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];

  // R4
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs[0] == '0);

  // R11
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/msc_core.sv
module msc_core
  import msc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  output logic            dmem_re_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int unsigned EXT_W = XLEN - IMM_W;
  localparam int unsigned PCH_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_res, wb_data;
  logic [5:0]      opc, funct;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic            alu_zero, rf_we;

  assign instr  = imem_rdata_i;
  assign opc    = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign funct  = instr[5:0];

  msc_main_dec u_main_dec (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  msc_alu_dec u_alu_dec (
    .aop_i   (ctrl.alu_op),
    .funct_i (funct),
    .fn_o    (alu_fn)
  );

  assign wr_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign rf_we  = ctrl.reg_we & rst_ni;

  msc_regfile #(.W(XLEN), .N(NREG)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (rs_idx),
    .raddr_b_i (rt_idx),
    .rdata_a_o (rs_data),
    .rdata_b_o (rt_data),
    .we_i      (rf_we),
    .waddr_i   (wr_idx),
    .wdata_i   (wb_data)
  );

  assign imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  msc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_res;

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1 -: PCH_W], instr[JIDX_W-1:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  pc_d = jmp_tgt;
    else if (ctrl.branch && alu_zero) pc_d = br_tgt;
    else                            pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_res;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;
  assign dmem_re_o    = ctrl.mem_re & rst_ni;

  // R6
  store_only_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (instr[31:26] == 6'd43));

  // R7
  beq_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == 6'd4 && rs_data == rt_data)
      |=> pc_q == $past(pc_q + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00}));

  // R8
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == 6'd2)
      |=> pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00});

  // R9
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] != 6'd2 && instr[31:26] != 6'd4) |=> pc_q == $past(pc_q) + 32'd4);
endmodule

// File: tb/msc_core_tb_top.sv
module msc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IM_WORDS   = 256;
  localparam int DM_WORDS   = 64;
  localparam int unsigned SEED = 32'h5eed_c0de;
  localparam int ROUNDS     = 6;
  localparam int ROUND_CYC  = 500;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem     [IM_WORDS];
  logic [31:0] dmem     [DM_WORDS];
  logic [31:0] ref_dmem [DM_WORDS];
  logic [31:0] ref_regs [32];
  logic [31:0] ref_pc;
  string       prev_tag;
  int          n_chk = 0;
  int          n_bad = 0;
  int          wp;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  msc_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_rdata_i (imem_rdata),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_re_o    (dmem_re),
    .dmem_rdata_i (dmem_rdata)
  );

  function automatic logic [31:0] r_ins(logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] j_ins(logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  function automatic logic [5:0] pick_fn(int unsigned k);
    case (k % 5)
      0: return 6'h20;
      1: return 6'h22;
      2: return 6'h24;
      3: return 6'h25;
      default: return 6'h2a;
    endcase
  endfunction

  function automatic logic [31:0] rand_instr();
    int unsigned k;
    logic [4:0]  ra, rb, rc;
    logic [5:0]  op;
    k  = $urandom_range(15, 0);
    ra = 5'($urandom_range(7, 0));
    rb = 5'($urandom_range(7, 0));
    rc = 5'($urandom_range(7, 0));
    case (k)
      6, 7:  return i_ins(6'd35, ra, rb, 16'($urandom_range(127, 0)) - 16'd64);
      8, 9:  return i_ins(6'd43, ra, rb, 16'($urandom_range(127, 0)) - 16'd64);
      10:    return i_ins(6'd4, ra, rb, 16'($urandom_range(15, 0)) - 16'd4);
      11:    return j_ins(26'($urandom_range(IM_WORDS - 1, 0)));
      12: begin
        do op = 6'($urandom_range(63, 0));
        while (op == 6'd0 || op == 6'd2 || op == 6'd4 || op == 6'd35 || op == 6'd43);
        return {op, ra, rb, 16'($urandom())};
      end
      default: return r_ins(rc, ra, rb, pick_fn($urandom()));
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  // instruction-level reference: check this cycle's port activity, then advance
  task automatic step();
    logic [31:0] ins, a, b, imm, res, npc, addr;
    logic        xwe, xre;
    string       ptag;
    ins  = imem[ref_pc[9:2]];
    a    = ref_regs[ins[25:21]];
    b    = ref_regs[ins[20:16]];
    imm  = {{16{ins[15]}}, ins[15:0]};
    npc  = ref_pc + 32'd4;
    xwe  = 1'b0;
    xre  = 1'b0;
    res  = '0;
    ptag = "R9";
    chk(prev_tag, "pc", imem_addr, ref_pc);
    case (ins[31:26])
      6'd0: begin
        case (ins[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2a: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = a + b;
        endcase
        if (ins[15:11] != 5'd0) ref_regs[ins[15:11]] = res;
      end
      6'd35: begin
        addr = a + imm;
        xre  = 1'b1;
        chk("R5", "load address", dmem_addr, addr);
        if (ins[20:16] != 5'd0) ref_regs[ins[20:16]] = ref_dmem[addr[7:2]];
      end
      6'd43: begin
        addr = a + imm;
        xwe  = 1'b1;
        chk("R6", "store address", dmem_addr, addr);
        chk("R6", "store data", dmem_wdata, b);
        ref_dmem[addr[7:2]] = b;
      end
      6'd4: begin
        ptag = "R7";
        if (a == b) npc = ref_pc + 32'd4 + {imm[29:0], 2'b00};
      end
      6'd2: begin
        ptag = "R8";
        npc  = {ref_pc[31:28], ins[25:0], 2'b00};
      end
      default: ptag = "R10";
    endcase
    chk(ptag == "R10" ? "R10" : "R6", "write strobe", {31'd0, dmem_we}, {31'd0, xwe});
    chk(ptag == "R10" ? "R10" : "R5", "read strobe", {31'd0, dmem_re}, {31'd0, xre});
    if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;
    ref_pc   = npc;
    prev_tag = ptag;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R1", "pc in reset", imem_addr, 32'd0);
      chk("R1", "we in reset", {31'd0, dmem_we}, 32'd0);
      chk("R1", "re in reset", {31'd0, dmem_re}, 32'd0);
    end
    ref_pc = '0;
    for (int i = 0; i < 32; i++) ref_regs[i] = '0;
    for (int i = 0; i < DM_WORDS; i++) ref_dmem[i] = dmem[i];
    prev_tag = "R1";
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      if (c != 0) @(negedge clk);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(SEED));
    for (int i = 0; i < IM_WORDS; i++) imem[i] = '0;
    for (int i = 0; i < DM_WORDS; i++) dmem[i] = 32'ha5a5_0000 | 32'(i);
    dmem[0] = 32'd5;
    dmem[1] = 32'hffff_fffd;
    dmem[2] = 32'h1234_5678;
    wp = 0;
    emit(i_ins(6'd35, 5'd0, 5'd1, 16'd0));     // 0  r1 = 5
    emit(i_ins(6'd35, 5'd0, 5'd2, 16'd4));     // 1  r2 = -3
    emit(r_ins(5'd3, 5'd1, 5'd2, 6'h20));      // 2  add
    emit(r_ins(5'd4, 5'd1, 5'd2, 6'h22));      // 3  sub
    emit(r_ins(5'd5, 5'd1, 5'd2, 6'h24));      // 4  and
    emit(r_ins(5'd6, 5'd1, 5'd2, 6'h25));      // 5  or
    emit(r_ins(5'd7, 5'd2, 5'd1, 6'h2a));      // 6  slt -3<5
    emit(r_ins(5'd8, 5'd1, 5'd2, 6'h2a));      // 7  slt 5<-3
    emit(r_ins(5'd0, 5'd1, 5'd1, 6'h20));      // 8  write to r0
    emit(i_ins(6'd43, 5'd0, 5'd3, 16'd16));    // 9
    emit(i_ins(6'd43, 5'd0, 5'd4, 16'd20));    // 10
    emit(i_ins(6'd43, 5'd0, 5'd5, 16'd24));    // 11
    emit(i_ins(6'd43, 5'd0, 5'd6, 16'd28));    // 12
    emit(i_ins(6'd43, 5'd0, 5'd7, 16'd32));    // 13
    emit(i_ins(6'd43, 5'd0, 5'd8, 16'd36));    // 14
    emit(i_ins(6'd43, 5'd0, 5'd0, 16'd40));    // 15
    emit(i_ins(6'h3f, 5'd0, 5'd1, 16'd4));     // 16 undefined opcode
    emit(i_ins(6'd43, 5'd0, 5'd1, 16'd60));    // 17
    emit(i_ins(6'd4, 5'd1, 5'd2, 16'd5));      // 18 not taken
    emit(i_ins(6'd4, 5'd1, 5'd1, 16'd2));      // 19 taken -> 22
    emit(i_ins(6'd43, 5'd0, 5'd1, 16'd44));    // 20 skipped
    emit(i_ins(6'd43, 5'd0, 5'd1, 16'd44));    // 21 skipped
    emit(j_ins(26'd25));                       // 22 -> 25
    emit(i_ins(6'd43, 5'd0, 5'd1, 16'd48));    // 23 skipped
    emit(i_ins(6'd43, 5'd0, 5'd1, 16'd48));    // 24 skipped
    emit(i_ins(6'd35, 5'd0, 5'd9, 16'd8));     // 25
    emit(i_ins(6'd43, 5'd4, 5'd9, 16'd44));    // 26 addr 52
    emit(i_ins(6'd35, 5'd4, 5'd10, 16'hfffc)); // 27 addr 4
    emit(i_ins(6'd43, 5'd0, 5'd10, 16'd56));   // 28
    emit(i_ins(6'd4, 5'd0, 5'd0, 16'hffff));   // 29 self loop

    do_reset();
    run(45);
    chk("R3", "add with load result", dmem[4], 32'd2);
    chk("R11", "back-to-back use", dmem[4], 32'd2);
    chk("R3", "sub", dmem[5], 32'd8);
    chk("R3", "and", dmem[6], 32'd5);
    chk("R3", "or", dmem[7], 32'hffff_fffd);
    chk("R3", "slt signed true", dmem[8], 32'd1);
    chk("R3", "slt signed false", dmem[9], 32'd0);
    chk("R4", "r0 after write", dmem[10], 32'd0);
    chk("R10", "undefined op no store", dmem[1], 32'hffff_fffd);
    chk("R10", "undefined op no reg write", dmem[15], 32'd5);
    chk("R7", "taken branch skip", dmem[11], 32'ha5a5_000b);
    chk("R8", "jump skip", dmem[12], 32'ha5a5_000c);
    chk("R5", "load via jump target", dmem[13], 32'h1234_5678);
    chk("R5", "negative offset load", dmem[14], 32'hffff_fffd);
    chk("R7", "backward self branch", imem_addr, 32'd116);
    chk("R2", "decode of all classes", {31'd0, dmem[4] == 32'd2 && dmem[12] == 32'ha5a5_000c}, 32'd1);

    for (int r = 0; r < ROUNDS; r++) begin
      rst_ni = 1'b0;
      for (int i = 0; i < IM_WORDS; i++) imem[i] = rand_instr();
      for (int i = 0; i < DM_WORDS; i++) dmem[i] = $urandom();
      do_reset();
      run(ROUND_CYC);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule